// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Warning Interrupt

This peripheral watches for a stalled system. A single tick counter runs on the input clock while the block is enabled. Two programmable limits are compared against it. The lower limit raises a warning interrupt, which gives software one last chance to react. The higher limit raises a request that the system be reset. Software keeps the system alive by writing a kick to the restart register, which sends the counter back to zero and withdraws both outputs.

Software reaches the block through a single-cycle register port. A write is accepted on the edge where `wr_en` is high. Read data is registered and appears one cycle after `rd_en`. A sticky flag records that a timeout reset happened. The flag is cleared only by power-on reset. The reset that the watchdog itself requests (`sys_rst`) leaves it unchanged, so software can read it after restarting. A parameter selects between two address layouts.

Top module: `wdog_two_stage`

## Requirements
- R1: After power-on reset, `warn_irq`, `reset_req` and `timeout_flag` are 0, and the enable and status registers read 0.
- R2: With `ALT_MAP`=0, the registers sit at these offsets: restart 0x04, enable 0x08, status 0x0C, warning limit 0x10, reset limit 0x14. A limit reads back the low `CNT_W` bits that were written to it. The restart register and any unmapped offset read 0. Read data is valid in the cycle after `rd_en`.
- R3: With `ALT_MAP`=1, the same registers sit at 0x38, 0x40, 0x44, 0x4C and 0x5C, and 0x10 is unmapped.
- R4: Bit 0 of the enable register turns counting on. While enabled, the counter advances by one per clock and saturates at its maximum. While disabled, it keeps its value, and counting resumes from that value on the next enable.
- R5: Start from a counter of 0, either on the write that sets enable or on a kick. `warn_irq` rises exactly W+1 cycles later, where W is the warning limit. It then stays high until a kick or a disable, so each timeout period gives one rising edge.
- R6: Under the same conditions, `reset_req` rises exactly R+1 cycles later, where R is the reset limit.
- R7: When both limits hold the same value, `warn_irq` and `reset_req` rise in the same cycle.
- R8: A write with bit 0 = 1 to the restart register clears the counter and both outputs. Kicks at intervals shorter than the warning limit keep both outputs low. A restart write with bit 0 = 0 has no effect.
- R9: A write of 0 to the enable register clears both outputs on that edge. Neither output asserts while the block is disabled.
- R10: Bit 0 of the status register (`timeout_flag`) is set on the edge where `reset_req` rises. It then stays set until power-on reset.
- R11: `sys_rst` clears the enable bit, the counter and both outputs, and returns both limits to all ones. It leaves `timeout_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the tick source |
| por_rst | input | 1 | Synchronous power-on reset, active high; clears everything |
| sys_rst | input | 1 | Synchronous system reset, active high; keeps the timeout flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| warn_irq | output | 1 | Warning interrupt level |
| reset_req | output | 1 | System reset request level |
| timeout_flag | output | 1 | Sticky record that a reset request fired |

## Verification
The assertions assume that `por_rst` is high from time zero and that `wr_en` and `rd_en` carry one address per cycle. They also assume that the limits are rewritten only while the block is disabled, so the comparison against the counter never sees a limit change in the middle of a period. The stimulus respects this: it clears enable, kicks, writes both limits and only then sets enable. It issues one bus access at a time, driven between clock edges.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [2:0] {
    SEL_NONE, SEL_KICK, SEL_EN, SEL_STAT, SEL_WARN, SEL_RST
  } wdt_sel_e;

  localparam int NUM_REGS = 5;

  // Offset of register idx (0 kick, 1 enable, 2 status, 3 warn, 4 reset)
  function automatic logic [7:0] reg_offset(input bit alt_map, input int idx);
    logic [7:0] off;
    case (idx)
      0: off = alt_map ? 8'h38 : 8'h04;
      1: off = alt_map ? 8'h40 : 8'h08;
      2: off = alt_map ? 8'h44 : 8'h0C;
      3: off = alt_map ? 8'h4C : 8'h10;
      default: off = alt_map ? 8'h5C : 8'h14;
    endcase
    return off;
  endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs import wdt_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag,
  output logic              en_q,
  output logic              en_nxt,
  output logic              kick,
  output logic [CNT_W-1:0]  warn_lim,
  output logic [CNT_W-1:0]  rst_lim,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [CNT_W-1:0] LIM_INIT = '1;

  wdt_sel_e sel;

  always_comb begin
    sel = SEL_NONE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(reg_offset(ALT_MAP, i)))
        sel = wdt_sel_e'(3'(i + 1));
    end
  end

  assign kick   = wr_en && (sel == SEL_KICK) && wdata[0];
  assign en_nxt = (wr_en && (sel == SEL_EN)) ? wdata[0] : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      warn_lim <= LIM_INIT;
      rst_lim  <= LIM_INIT;
    end else if (wr_en) begin
      case (sel)
        SEL_EN:   en_q     <= wdata[0];
        SEL_WARN: warn_lim <= wdata[CNT_W-1:0];
        SEL_RST:  rst_lim  <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        SEL_EN:   rdata <= {{(DATA_W-1){1'b0}}, en_q};
        SEL_STAT: rdata <= {{(DATA_W-1){1'b0}}, flag};
        SEL_WARN: rdata <= DATA_W'(warn_lim);
        SEL_RST:  rdata <= DATA_W'(rst_lim);
        default:  rdata <= '0;
      endcase
    end
  end

  // R4: an enable write lands on the next edge
  a_r4_enable_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_EN) |=> (en_q == $past(wdata[0])));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             en_nxt,
  input  logic             kick,
  input  logic [CNT_W-1:0] warn_lim,
  input  logic [CNT_W-1:0] rst_lim,
  output logic             warn_q,
  output logic             bite_q,
  output logic             bite_hit
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic             run;

  assign run      = en_q && en_nxt && !kick;
  assign bite_hit = run && (cnt >= rst_lim) && !bite_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      warn_q <= 1'b0;
      bite_q <= 1'b0;
    end else if (kick) begin
      cnt    <= '0;
      warn_q <= 1'b0;
      bite_q <= 1'b0;
    end else if (!en_nxt) begin
      warn_q <= 1'b0;
      bite_q <= 1'b0;
    end else if (en_q) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt >= warn_lim) warn_q <= 1'b1;
      if (cnt >= rst_lim)  bite_q <= 1'b1;
    end
  end

  // R8: a kick zeroes the counter and both outputs
  a_r8_kick_clears: assert property (@(posedge clk) disable iff (rst)
    kick |=> (cnt == '0 && !warn_q && !bite_q));
  // R9: nothing asserts while disabled
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> (!warn_q && !bite_q));
  // R4: counter holds while disabled
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !kick) |=> $stable(cnt));
  // R5: warning is a level until kick or disable
  a_r5_warn_level: assert property (@(posedge clk) disable iff (rst)
    (warn_q && en_nxt && !kick) |=> warn_q);
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause (
  input  logic clk,
  input  logic por_rst,
  input  logic bite_hit,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (por_rst) flag_q <= 1'b0;
    else if (bite_hit) flag_q <= 1'b1;
  end

  // R10: flag set on the firing edge and never dropped
  a_r10_flag_set: assert property (@(posedge clk) disable iff (por_rst)
    bite_hit |=> flag_q);
  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (por_rst)
    flag_q |=> flag_q);
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 29,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              por_rst,
  input  logic              sys_rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              warn_irq,
  output logic              reset_req,
  output logic              timeout_flag
);
  logic             rst;
  logic             en_q, en_nxt, kick, bite_hit;
  logic [CNT_W-1:0] warn_lim, rst_lim;

  assign rst = por_rst | sys_rst;

  wdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ALT_MAP(ALT_MAP)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flag(timeout_flag), .en_q(en_q), .en_nxt(en_nxt),
    .kick(kick), .warn_lim(warn_lim), .rst_lim(rst_lim), .rdata(rdata)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_q(en_q), .en_nxt(en_nxt), .kick(kick),
    .warn_lim(warn_lim), .rst_lim(rst_lim), .warn_q(warn_irq),
    .bite_q(reset_req), .bite_hit(bite_hit)
  );

  wdt_cause u_cause (
    .clk(clk), .por_rst(por_rst), .bite_hit(bite_hit), .flag_q(timeout_flag)
  );

  // R11: system reset drops both outputs and spares the flag
  a_r11_sys_rst: assert property (@(posedge clk) disable iff (por_rst)
    sys_rst |=> (!warn_irq && !reset_req && timeout_flag == $past(timeout_flag)));
endmodule

// File: tb/sim_wdog_two_stage.sv
module sim_wdog_two_stage;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_KICK = 8'h04, A_EN = 8'h08, A_STAT = 8'h0C,
                         A_WARN = 8'h10, A_RST = 8'h14;

  logic clk = 1'b0;
  logic por_rst = 1'b1, sys_rst = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, wr1 = 1'b0, rd1 = 1'b0;
  logic [7:0]  addr = '0, addr1 = '0;
  logic [31:0] wdata = '0, wdata1 = '0, rdata, rdata1;
  logic warn_irq, reset_req, timeout_flag, warn1, bite1, flag1;
  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int cyc; int kind; logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_two_stage u0 (.clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .warn_irq(warn_irq), .reset_req(reset_req), .timeout_flag(timeout_flag));

  wdog_two_stage #(.ALT_MAP(1'b1)) u1 (.clk(clk), .por_rst(por_rst), .sys_rst(sys_rst),
    .wr_en(wr1), .rd_en(rd1), .addr(addr1), .wdata(wdata1), .rdata(rdata1),
    .warn_irq(warn1), .reset_req(bite1), .timeout_flag(flag1));

  function automatic logic [31:0] pick(int kind);
    case (kind)
      0: return {31'b0, warn_irq};
      1: return {31'b0, reset_req};
      2: return {31'b0, timeout_flag};
      3: return rdata;
      default: return rdata1;
    endcase
  endfunction

  // monitor: pop items due this cycle and compare
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc <= cyc) begin
        logic [31:0] got;
        got = pick(sb[i].kind);
        checks++;
        if (sb[i].cyc < cyc || got !== sb[i].exp) begin
          errors++;
          $display("FAIL %s: kind %0d cycle %0d got %0h expected %0h",
                   sb[i].tag, sb[i].kind, sb[i].cyc, got, sb[i].exp);
        end
        sb.delete(i);
      end
    end
  end

  task automatic push(input int c, input int kind, input logic [31:0] v, input string tag);
    item_t it;
    it.cyc = c; it.kind = kind; it.exp = v; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic wr(input bit alt, input logic [7:0] a, input logic [31:0] d, output int w);
    @(negedge clk);
    if (alt) begin addr1 = a; wdata1 = d; wr1 = 1'b1; end
    else begin addr = a; wdata = d; wr_en = 1'b1; end
    @(negedge clk);
    wr1 = 1'b0; wr_en = 1'b0;
    w = cyc;
  endtask

  task automatic rd(input bit alt, input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    if (alt) begin addr1 = a; rd1 = 1'b1; end
    else begin addr = a; rd_en = 1'b1; end
    push(cyc + 1, alt ? 4 : 3, e, tag);
    @(negedge clk);
    rd1 = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      summary();
    end
  end

  initial begin
    int w, e, k, d;
    repeat (3) @(negedge clk);
    por_rst = 1'b0;
    push(cyc + 1, 0, 0, "R1 warn"); push(cyc + 1, 1, 0, "R1 reset_req");
    push(cyc + 1, 2, 0, "R1 flag");
    rd(0, A_EN, 0, "R1 enable reg"); rd(0, A_STAT, 0, "R1 status reg");

    // Phase A: limits, readback, timeout, flag
    wr(0, A_WARN, 5, w); wr(0, A_RST, 9, w);
    rd(0, A_WARN, 5, "R2 warn limit"); rd(0, A_RST, 9, "R2 reset limit");
    rd(0, A_KICK, 0, "R2 restart reads 0"); rd(0, 8'h20, 0, "R2 unmapped");
    wr(0, A_KICK, 1, w); wr(0, A_EN, 1, e);
    push(e + 5, 0, 0, "R5 warn early"); push(e + 6, 0, 1, "R5 warn rise");
    push(e + 9, 1, 0, "R6 reset early"); push(e + 10, 1, 1, "R6 reset rise");
    push(e + 9, 2, 0, "R10 flag early"); push(e + 10, 2, 1, "R10 flag set");
    push(e + 11, 0, 1, "R5 warn held");
    wait_until(e + 12);
    wr(0, A_KICK, 0, w);
    push(w + 1, 0, 1, "R8 zero kick ignored"); push(w + 1, 1, 1, "R8 zero kick ignored");
    rd(0, A_STAT, 1, "R10 status bit");
    @(negedge clk); sys_rst = 1'b1; @(negedge clk); sys_rst = 1'b0;
    push(cyc + 1, 0, 0, "R11 warn"); push(cyc + 1, 1, 0, "R11 reset_req");
    push(cyc + 1, 2, 1, "R10 flag survives sys_rst");
    rd(0, A_EN, 0, "R11 enable cleared"); rd(0, A_WARN, 32'h1FFF_FFFF, "R11 limit default");

    // Phase B: regular kicks keep it quiet
    wr(0, A_WARN, 5, w); wr(0, A_RST, 9, w); wr(0, A_KICK, 1, w); wr(0, A_EN, 1, e);
    for (int i = 0; i < 10; i++) begin
      wr(0, A_KICK, 1, w);
      push(w + 1, 0, 0, "R8 kicked warn"); push(w + 1, 1, 0, "R8 kicked reset_req");
    end
    // Phase C: disable holds count
    wr(0, A_KICK, 1, k); wr(0, A_EN, 0, d);
    for (int i = 1; i <= 20; i++) begin
      push(d + i, 0, 0, "R9 idle warn"); push(d + i, 1, 0, "R9 idle reset_req");
    end
    wait_until(d + 21);
    wr(0, A_EN, 1, e);
    push(e + 5 - (d - k - 1), 0, 0, "R4 resume early");
    push(e + 6 - (d - k - 1), 0, 1, "R4 resume from held count");
    wait_until(e + 8);
    wr(0, A_EN, 0, w);

    // Phase D: equal limits, then disable clears
    wr(0, A_WARN, 7, w); wr(0, A_RST, 7, w); wr(0, A_KICK, 1, w); wr(0, A_EN, 1, e);
    push(e + 7, 0, 0, "R7 warn early"); push(e + 7, 1, 0, "R7 reset early");
    push(e + 8, 0, 1, "R7 warn same cycle"); push(e + 8, 1, 1, "R7 reset same cycle");
    push(e + 14, 0, 1, "R5 level persists");
    wait_until(e + 15);
    wr(0, A_EN, 0, w);
    for (int i = 1; i <= 10; i++) begin
      push(w + i, 0, 0, "R9 disable clears warn"); push(w + i, 1, 0, "R9 disable clears reset_req");
    end
    wait_until(w + 11);

    // Phase E: alternate layout
    wr(1, 8'h4C, 32'h123, w); rd(1, 8'h4C, 32'h123, "R3 alt warn limit");
    wr(1, 8'h40, 1, w); rd(1, 8'h40, 1, "R3 alt enable");
    rd(1, 8'h10, 0, "R3 default offset unmapped");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    summary();
  end
endmodule